// File: doc/BRIEF.md
# Streaming SAXPY Vector Unit

This block computes Y = a*X + Y in place over integer vectors held in word memory. A start pulse supplies the address of the scalar a, the base addresses of X and Y, and an element count. The unit then works through a fixed series of phases with no further control:

1. Read the scalar.
2. Stream X into a queue register.
3. Scale each queued element by a into a product queue.
4. Stream Y into its own queue.
5. Sum the product and Y queues into a result queue.
6. Drain the result queue back over Y.

A single-cycle done pulse closes the operation.

Each vector register is a first-in first-out queue. Elements enter at the tail and leave from the head, and no register has an index port. Arithmetic is 32-bit two's complement, keeping the low 32 bits.

The memory port is a single synchronous word port with a one-cycle read latency. A loader issues one address per cycle. Each element-wise stage handles one pair per cycle. The store phase writes one word per clock.

Top module: `vsaxpy_unit`

## Requirements
- R1: After reset, done and mem_we are low, and no memory write happens until a start is accepted.
- R2: For each i below the effective length, the word written at address y_base+i is the low 32 bits of a*X[i]+Y[i]. Writes go in ascending i order, and no other address is written.
- R3: A requested length above 64 is treated as 64: exactly 64 words are written, and the word at y_base+64 keeps its value.
- R4: A start with length zero raises done in the next cycle, and no memory write takes place.
- R5: Once the store phase begins, mem_we stays high on every clock until the last result word, with no gap.
- R6: done is high for exactly one cycle per accepted start. For a non-zero length it is raised in the cycle right after the last write.
- R7: A start pulse that arrives while an operation runs is ignored. Its addresses and length have no effect on the writes of the running operation.
- R8: Each vector queue holds 64 elements. A full 64-element operation completes with every result correct, and no queue overflows or underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| scal_addr | input | 16 | Address of the scalar a |
| x_base | input | 16 | Base address of vector X |
| y_base | input | 16 | Base address of vector Y, and of the result |
| vec_len | input | 8 | Requested element count |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 32 | Memory read data, valid one cycle after its address |

## Verification
Done for a zero-length start is due at the first falling edge after the edge that samples start. The bench samples done exactly there, and expects it low at that same point for any other length.

Each result word is due in the cycle that mem_we is high. A scoreboard compares it at the falling edge against the next expected (address, data) pair queued by the driver. Every write after the first must follow a write in the previous cycle.

Done must appear in the cycle right after the last write, so the monitor compares the pulse with the write enable it saw one cycle earlier. A few settle cycles after each run confirm that no second pulse or stray write follows.

// File: rtl/vsaxpy_pkg.sv
package vsaxpy_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LDS,
      PH_LDX,
      PH_MUL,
      PH_LDY,
      PH_ADD,
      PH_ST
   } phase_t;

   // queue register slots
   localparam int VQ_X   = 0;
   localparam int VQ_P   = 1;
   localparam int VQ_Y   = 2;
   localparam int VQ_R   = 3;
   localparam int VQ_NUM = 4;
endpackage

// File: rtl/vreg_fifo.sv
module vreg_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
         $error("vreg_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  store [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + PW'(1);
         if (pop)  rp <= rp + PW'(1);
         cnt <= cnt + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) store[wp] <= din;
   end

   assign head  = store[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));

   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop));
   a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/vec_elem_stage.sv
module vec_elem_stage #(
   parameter int W      = 32,
   parameter bit DO_MUL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fire,
   input  logic [W-1:0] lhs,
   input  logic [W-1:0] rhs,
   output logic         out_valid,
   output logic [W-1:0] out_data
);
   logic [W-1:0] res;

   generate
      if (DO_MUL) begin : g_mul
         assign res = lhs * rhs;
      end else begin : g_add
         assign res = lhs + rhs;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= fire;
         if (fire) out_data <= res;
      end
   end

   a_r8_one_result_per_fire: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> out_valid);
endmodule

// File: rtl/vsaxpy_unit.sv
module vsaxpy_unit
   import vsaxpy_pkg::*;
#(
   parameter int DW    = 32,
   parameter int AW    = 16,
   parameter int DEPTH = 64,
   parameter int LW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] scal_addr,
   input  logic [AW-1:0] x_base,
   input  logic [AW-1:0] y_base,
   input  logic [LW-1:0] vec_len,
   output logic          done,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_we,
   input  logic [DW-1:0] mem_rdata
);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if ((1 << LW) <= DEPTH) begin : g_bad_lw
         $error("vsaxpy_unit: LW too narrow to request a full-depth vector");
      end
   endgenerate

   phase_t        phase;
   logic [DW-1:0] a_reg;
   logic [AW-1:0] sa, xb, yb;
   logic [CW-1:0] len, iss_cnt, st_cnt;
   logic          rsp_v;

   logic [VQ_NUM-1:0] q_push, q_pop, q_empty, q_full;
   logic [DW-1:0]     q_din  [VQ_NUM];
   logic [DW-1:0]     q_head [VQ_NUM];

   logic          mul_ov, add_ov;
   logic [DW-1:0] mul_out, add_out;

   // Start decode and length clamp
   logic [CW-1:0] len_clamped;
   assign len_clamped = (vec_len > LW'(DEPTH)) ? CW'(DEPTH) : CW'(vec_len);

   // Loader
   logic          is_load, issue, ld_done;
   logic [CW-1:0] ld_lim;
   logic [AW-1:0] ld_base;
   always_comb begin
      is_load = (phase == PH_LDS) || (phase == PH_LDX) || (phase == PH_LDY);
      ld_lim  = (phase == PH_LDS) ? CW'(1) : len;
      ld_base = (phase == PH_LDS) ? sa : ((phase == PH_LDX) ? xb : yb);
      issue   = is_load && (iss_cnt < ld_lim);
      ld_done = is_load && (iss_cnt == ld_lim) && !rsp_v;
   end

   // Element-wise stages and store
   logic mul_fire, mul_done, add_fire, add_done, st_fire, st_last;
   always_comb begin
      mul_fire = (phase == PH_MUL) && !q_empty[VQ_X];
      mul_done = (phase == PH_MUL) && q_empty[VQ_X] && !mul_ov;
      add_fire = (phase == PH_ADD) && !q_empty[VQ_P] && !q_empty[VQ_Y];
      add_done = (phase == PH_ADD) && q_empty[VQ_P] && !add_ov;
      st_fire  = (phase == PH_ST) && !q_empty[VQ_R];
      st_last  = st_fire && (st_cnt == len - CW'(1));
   end

   always_comb begin
      q_push[VQ_X] = rsp_v && (phase == PH_LDX);
      q_push[VQ_Y] = rsp_v && (phase == PH_LDY);
      q_push[VQ_P] = mul_ov;
      q_push[VQ_R] = add_ov;
      q_din[VQ_X]  = mem_rdata;
      q_din[VQ_Y]  = mem_rdata;
      q_din[VQ_P]  = mul_out;
      q_din[VQ_R]  = add_out;
      q_pop[VQ_X]  = mul_fire;
      q_pop[VQ_P]  = add_fire;
      q_pop[VQ_Y]  = add_fire;
      q_pop[VQ_R]  = st_fire;
   end

   generate
      for (genvar g = 0; g < VQ_NUM; g++) begin : g_vq
         vreg_fifo #(.W(DW), .DEPTH(DEPTH)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[g]),
            .din   (q_din[g]),
            .pop   (q_pop[g]),
            .head  (q_head[g]),
            .empty (q_empty[g]),
            .full  (q_full[g])
         );
      end
   endgenerate

   vec_elem_stage #(.W(DW), .DO_MUL(1'b1)) u_mul (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (mul_fire),
      .lhs       (q_head[VQ_X]),
      .rhs       (a_reg),
      .out_valid (mul_ov),
      .out_data  (mul_out)
   );

   vec_elem_stage #(.W(DW), .DO_MUL(1'b0)) u_add (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (add_fire),
      .lhs       (q_head[VQ_P]),
      .rhs       (q_head[VQ_Y]),
      .out_valid (add_ov),
      .out_data  (add_out)
   );

   // Memory port
   assign mem_we    = st_fire;
   assign mem_wdata = q_head[VQ_R];
   assign mem_addr  = st_fire ? (yb + AW'(st_cnt)) : (ld_base + AW'(iss_cnt));

   // Phase sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         a_reg   <= '0;
         sa      <= '0;
         xb      <= '0;
         yb      <= '0;
         len     <= '0;
         iss_cnt <= '0;
         st_cnt  <= '0;
         rsp_v   <= 1'b0;
         done    <= 1'b0;
      end else begin
         done  <= 1'b0;
         rsp_v <= issue;
         if (rsp_v && phase == PH_LDS) a_reg <= mem_rdata;
         if (issue) iss_cnt <= iss_cnt + CW'(1);
         if (ld_done) iss_cnt <= '0;
         case (phase)
            PH_IDLE: if (start) begin
               if (len_clamped == '0) begin
                  done <= 1'b1;
               end else begin
                  phase <= PH_LDS;
                  sa    <= scal_addr;
                  xb    <= x_base;
                  yb    <= y_base;
                  len   <= len_clamped;
               end
            end
            PH_LDS: if (ld_done) phase <= PH_LDX;
            PH_LDX: if (ld_done) phase <= PH_MUL;
            PH_MUL: if (mul_done) phase <= PH_LDY;
            PH_LDY: if (ld_done) phase <= PH_ADD;
            PH_ADD: if (add_done) phase <= PH_ST;
            PH_ST: begin
               if (st_fire) st_cnt <= st_cnt + CW'(1);
               if (st_last) begin
                  st_cnt <= '0;
                  phase  <= PH_IDLE;
                  done   <= 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   a_r5_store_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ST) |-> mem_we);
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r2_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ((mem_addr - yb) < AW'(len)));
   a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && start) |=> ($stable(xb) && $stable(yb) && $stable(len)));
endmodule

// File: tb/vsaxpy_unit_tb_top.sv
module vsaxpy_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] scal_addr = '0, x_base = '0, y_base = '0;
   logic [7:0]  vec_len = '0;
   logic        done, mem_we;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;

   always #5 clk = ~clk;

   vsaxpy_unit dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .scal_addr (scal_addr),
      .x_base    (x_base),
      .y_base    (y_base),
      .vec_len   (vec_len),
      .done      (done),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata)
   );

   logic [31:0] mem [1024];
   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[9:0]];
   end

   int checks = 0, failures = 0, cycles = 0;
   int run_writes = 0, done_seen = 0;
   bit prev_we = 1'b0;
   logic [47:0] exp_q [$];
   logic [47:0] exp_e;

   task automatic report(input string req, input string what, input longint act, input longint exp);
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_we) begin
            checks++;
            if (exp_q.size() == 0) begin
               report("R2", "unexpected write", {mem_addr, mem_wdata}, 0);
            end else begin
               exp_e = exp_q.pop_front();
               if ({mem_addr, mem_wdata} !== exp_e)
                  report("R2", "write addr/data", {mem_addr, mem_wdata}, exp_e);
            end
            if (run_writes > 0) begin
               checks++;
               if (!prev_we) report("R5", "gap in store stream", 0, 1);
            end
            run_writes++;
         end
         if (done) begin
            done_seen++;
            if (run_writes > 0) begin
               checks++;
               if (!prev_we) report("R6", "done not right after last write", 0, 1);
            end
         end
         prev_we = mem_we;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         report("R6", "watchdog cycles", cycles, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic run_case(input int sa, input int xb, input int yb, input int lenv,
                           input logic [31:0] a, input int seed, input bit poke);
      int eff = (lenv > 64) ? 64 : lenv;
      logic [31:0] sent = 32'hA5A5_0000 + 32'(seed);
      int cyc = 0;
      mem[sa] = a;
      for (int i = 0; i < eff; i++) begin
         logic [31:0] xv = 32'(seed * 7919 + i * 104729 - 3000000);
         logic [31:0] yv = 32'(seed * 31 - i * 977);
         logic [31:0] rv = a * xv + yv;
         mem[xb + i] = xv;
         mem[yb + i] = yv;
         exp_q.push_back({16'(yb + i), rv});
      end
      mem[yb + eff] = sent;
      run_writes = 0;
      done_seen  = 0;
      @(negedge clk);
      scal_addr = 16'(sa); x_base = 16'(xb); y_base = 16'(yb); vec_len = 8'(lenv);
      start = 1'b1;
      @(negedge clk);
      checks++;
      if (lenv == 0) begin
         if (done !== 1'b1) report("R4", "done one cycle after zero-length start", done, 1);
      end else if (done !== 1'b0) report("R6", "done too early", done, 0);
      start = 1'b0;
      if (lenv != 0) begin
         while (done !== 1'b1 && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 20) begin
               x_base = 16'(xb + 1); y_base = 16'(yb + 200); vec_len = 8'd3;
               start = 1'b1;
            end else start = 1'b0;
         end
      end
      repeat (4) @(negedge clk);
      checks++;
      if (done_seen != 1) report("R6", "done pulse count", done_seen, 1);
      checks++;
      if (run_writes != eff)
         report(poke ? "R7" : (lenv == 0 ? "R4" : "R2"), "write count", run_writes, eff);
      checks++;
      if (exp_q.size() != 0) report("R2", "missing results", exp_q.size(), 0);
      checks++;
      if (mem[yb + eff] !== sent) report("R3", "word past last element", mem[yb + eff], sent);
      exp_q.delete();
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      checks++;
      if (done !== 1'b0 || mem_we !== 1'b0) report("R1", "outputs in reset", {done, mem_we}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      checks++;
      if (done !== 1'b0 || mem_we !== 1'b0) report("R1", "outputs idle after reset", {done, mem_we}, 0);

      run_case(3, 100, 300, 4, 32'd5, 1, 1'b0);            // R2 short vector
      run_case(5, 400, 500, 1, 32'hFFFF_FFF9, 2, 1'b0);    // R2 single element, negative a
      run_case(7, 10, 600, 64, 32'hFFFF_FFFD, 3, 1'b1);    // R8 full depth, R7 busy start
      run_case(9, 200, 700, 100, 32'h7FFF_FFFF, 4, 1'b0);  // R3 clamp, R2 wraparound
      run_case(11, 20, 900, 0, 32'd3, 5, 1'b0);            // R4 zero length

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule